// File: doc/BRIEF.md
# ASID-Tagged Translation Cache

This block turns virtual addresses from a CPU into physical addresses. It keeps a small fully associative set of recent translations, each tagged with an address-space identifier (ASID). Every lookup compares the virtual page number and the current ASID against all slots at once. On a match, the stored frame number is joined to the untouched page offset, and the result is returned in the same cycle. When no slot matches, the block asks an external page-table walker for the translation, waits for the answer, and returns it to the CPU. It also stores the answer, so later accesses to that page hit.

A translation from the walker can be marked illegal. This means the page lies outside the process's address space. Such a translation is returned as a fault, with no address, and is cached as a faulting translation. Software can clear the whole cache at once, or clear only the slots that belong to one ASID.

The controller has two states. In `ST_LOOKUP` the port is ready and lookups are served. A request accepted with no matching slot causes the transition *miss* to `ST_WALK`. In `ST_WALK` the walk request is held and new requests are refused. The arrival of `fill_valid` causes the transition *fill* back to `ST_LOOKUP`. In that same cycle the response is produced and the translation is installed. Reset enters `ST_LOOKUP`.

Top module: `xlat_cache`

## Requirements
- R1: After reset every slot is empty, `rsp_ready` is 1, and `walk_req` and `rsp_valid` are 0. The first lookup of any page therefore misses.
- R2: The virtual page number is `req_vaddr[31:10]` and the offset is `req_vaddr[9:0]`. When `rsp_ready` and `req_valid` are high and a slot matches, `rsp_valid` is 1 in that same cycle, `rsp_fault` is 0 for a legal slot, and `rsp_paddr` = {stored frame, `req_vaddr[9:0]`}.
- R3: A slot matches only when both its page number and its ASID equal the request's. The same page under another ASID misses and gets a slot of its own.
- R4: An accepted request with no match raises `walk_req` in the next cycle, carrying that request's page number on `walk_vpn` and its ASID on `walk_asid`. Both are held stable until the cycle in which `fill_valid` is high. `rsp_ready` is 0 whenever `walk_req` is 1.
- R5: In the cycle where `fill_valid` is high during a walk, `rsp_valid` is 1 with `rsp_paddr` = {`fill_pfn`, saved offset}. `walk_req` falls in the next cycle, and the translation is installed, so a repeat of the same access hits.
- R6: If `fill_fault` is 1, the response has `rsp_fault` = 1 and `rsp_paddr` = 0. The translation is cached as illegal, so later lookups of that page fault in the same cycle without a walk. In any cycle without `rsp_valid`, both `rsp_fault` and `rsp_paddr` are 0.
- R7: A fill goes into the lowest-numbered empty slot. If no slot is empty, it replaces the slot at a rotating pointer. The pointer is 0 after reset and advances by one, wrapping, only on such a replacement. The victim is chosen from the occupancy as it stood before any flush applied in the same cycle.
- R8: When `flush_all` is 1, every slot is emptied at the clock edge. While either flush input is high, `rsp_ready` is 0 and any request in that cycle is ignored.
- R9: When `flush_sel` is 1, only the slots whose ASID equals `flush_sel_asid` are emptied. All other slots keep their translations.
- R10: When a flush and a fill occur in the same cycle, the flush is applied first, and the newly installed translation survives.
- R11: Requests presented during a walk have no effect: no response is produced, and `walk_vpn`/`walk_asid` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | CPU presents a lookup |
| req_vaddr | input | 32 | Virtual address |
| req_asid | input | 8 | ASID of the current process |
| rsp_ready | output | 1 | Lookup port can accept a request this cycle |
| rsp_valid | output | 1 | Translation result is valid this cycle |
| rsp_paddr | output | 30 | Physical address (frame and offset), 0 on fault |
| rsp_fault | output | 1 | Translation is illegal for this process |
| walk_req | output | 1 | Request to the page-table walker |
| walk_vpn | output | 22 | Page number to be walked |
| walk_asid | output | 8 | ASID of the walked page |
| fill_valid | input | 1 | Walker returns a result |
| fill_pfn | input | 20 | Frame number from the walker |
| fill_fault | input | 1 | Walker reports the page as illegal |
| flush_all | input | 1 | Empty every slot |
| flush_sel | input | 1 | Empty the slots of one ASID |
| flush_sel_asid | input | 8 | ASID selected for `flush_sel` |

## Verification
The bench aims at these corner cases:

- **Same page under two ASIDs.** A match that ignored the ASID would serve one process the other's frame.
- **A full cache.** Once every slot is used, a wrong victim choice or pointer step would evict a different page. The next access would then be wrongly reported as a hit or a miss.
- **Holes left by a per-ASID flush.** These must be refilled before the pointer is used. A design that ignored holes would evict live entries instead.
- **A flush in the same cycle as a fill.** A design that let the flush win would lose the fresh entry and walk again.
- **Stray requests during a walk.** A design that accepted them would answer them or disturb the held walk address.
- **Cached faulting pages.** These must fault again without a walk. A design that skipped caching them would show up as an extra walk.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;

    typedef enum logic {
        ST_LOOKUP = 1'b0,
        ST_WALK   = 1'b1
    } xlat_state_e;

endpackage

// File: rtl/xlat_cam.sv
`timescale 1ns/1ps
module xlat_cam #(
    parameter int SLOTS  = 16,
    parameter int VPN_W  = 22,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 20,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic              wr_legal,
    input  logic              flush_all,
    input  logic              flush_sel,
    input  logic [ASID_W-1:0] flush_sel_asid,
    output logic [SLOTS-1:0]  hit_vec,
    output logic              hit,
    output logic [PFN_W-1:0]  hit_pfn,
    output logic              hit_legal,
    output logic [SLOTS-1:0]  occ_vec
);

    logic [PFN_W-1:0] pfn_arr [SLOTS];
    logic [SLOTS-1:0] legal_vec;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic              occ_q;
        logic              legal_q;
        logic [VPN_W-1:0]  vpn_q;
        logic [ASID_W-1:0] asid_q;
        logic [PFN_W-1:0]  pfn_q;
        logic              take;
        logic              wipe;

        assign take = wr_en && (wr_idx == IDX_W'(s));
        assign wipe = flush_all || (flush_sel && (asid_q == flush_sel_asid));

        // a fill into this slot overrides a flush in the same cycle
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                occ_q <= 1'b0;
            end else if (take) begin
                occ_q <= 1'b1;
            end else if (wipe) begin
                occ_q <= 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vpn_q   <= '0;
                asid_q  <= '0;
                pfn_q   <= '0;
                legal_q <= 1'b0;
            end else if (take) begin
                vpn_q   <= wr_vpn;
                asid_q  <= wr_asid;
                pfn_q   <= wr_pfn;
                legal_q <= wr_legal;
            end
        end

        assign hit_vec[s]   = occ_q && (vpn_q == lk_vpn) && (asid_q == lk_asid);
        assign occ_vec[s]   = occ_q;
        assign legal_vec[s] = legal_q;
        assign pfn_arr[s]   = pfn_q;
    end

    always_comb begin
        hit_pfn = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (hit_vec[s]) begin
                hit_pfn = hit_pfn | pfn_arr[s];
            end
        end
    end

    assign hit       = |hit_vec;
    assign hit_legal = |(hit_vec & legal_vec);

endmodule

// File: rtl/xlat_victim.sv
`timescale 1ns/1ps
module xlat_victim #(
    parameter int SLOTS  = 16,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] occ_vec,
    input  logic             install,
    output logic [IDX_W-1:0] vic_idx
);

    logic             has_free;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] rr_next;

    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (!occ_vec[s]) begin
                has_free = 1'b1;
                free_idx = IDX_W'(s);
            end
        end
    end

    if (SLOTS == (1 << IDX_W)) begin : g_pow2
        assign rr_next = rr_q + IDX_W'(1);
    end else begin : g_wrap
        assign rr_next = (rr_q == IDX_W'(SLOTS - 1)) ? '0 : rr_q + IDX_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (install && !has_free) begin
            rr_q <= rr_next;
        end
    end

    assign vic_idx = has_free ? free_idx : rr_q;

endmodule

// File: rtl/xlat_ctrl.sv
`timescale 1ns/1ps
module xlat_ctrl
    import xlat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic flush_any,
    input  logic hit,
    input  logic fill_valid,
    output logic ready,
    output logic capture,
    output logic fill_done,
    output logic walking
);

    xlat_state_e state_q;
    xlat_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOOKUP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        ready     = 1'b0;
        capture   = 1'b0;
        fill_done = 1'b0;
        walking   = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                ready = !flush_any;
                if (!flush_any && req_valid && !hit) begin
                    capture = 1'b1;
                    state_d = ST_WALK;
                end
            end
            ST_WALK: begin
                walking = 1'b1;
                if (fill_valid) begin
                    fill_done = 1'b1;
                    state_d   = ST_LOOKUP;
                end
            end
        endcase
    end

endmodule

// File: rtl/xlat_cache.sv
`timescale 1ns/1ps
module xlat_cache #(
    parameter int VA_W   = 32,
    parameter int OFF_W  = 10,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 20,
    parameter int SLOTS  = 16,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PA_W  = PFN_W + OFF_W,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [ASID_W-1:0] req_asid,
    output logic              rsp_ready,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    output logic              walk_req,
    output logic [VPN_W-1:0]  walk_vpn,
    output logic [ASID_W-1:0] walk_asid,
    input  logic              fill_valid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              fill_fault,
    input  logic              flush_all,
    input  logic              flush_sel,
    input  logic [ASID_W-1:0] flush_sel_asid
);

    logic [VPN_W-1:0]  req_vpn;
    logic [OFF_W-1:0]  req_off;
    logic [VPN_W-1:0]  held_vpn;
    logic [ASID_W-1:0] held_asid;
    logic [OFF_W-1:0]  held_off;
    logic [SLOTS-1:0]  hit_vec;
    logic [SLOTS-1:0]  occ_vec;
    logic              hit;
    logic              hit_legal;
    logic [PFN_W-1:0]  hit_pfn;
    logic [IDX_W-1:0]  vic_idx;
    logic              ready;
    logic              capture;
    logic              fill_done;
    logic              walking;
    logic              served_hit;

    assign req_vpn = req_vaddr[VA_W-1:OFF_W];
    assign req_off = req_vaddr[OFF_W-1:0];

    xlat_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .flush_any  (flush_all | flush_sel),
        .hit        (hit),
        .fill_valid (fill_valid),
        .ready      (ready),
        .capture    (capture),
        .fill_done  (fill_done),
        .walking    (walking)
    );

    xlat_cam #(
        .SLOTS  (SLOTS),
        .VPN_W  (VPN_W),
        .ASID_W (ASID_W),
        .PFN_W  (PFN_W)
    ) u_cam (
        .clk            (clk),
        .rst_n          (rst_n),
        .lk_vpn         (req_vpn),
        .lk_asid        (req_asid),
        .wr_en          (fill_done),
        .wr_idx         (vic_idx),
        .wr_vpn         (held_vpn),
        .wr_asid        (held_asid),
        .wr_pfn         (fill_pfn),
        .wr_legal       (!fill_fault),
        .flush_all      (flush_all),
        .flush_sel      (flush_sel),
        .flush_sel_asid (flush_sel_asid),
        .hit_vec        (hit_vec),
        .hit            (hit),
        .hit_pfn        (hit_pfn),
        .hit_legal      (hit_legal),
        .occ_vec        (occ_vec)
    );

    xlat_victim #(
        .SLOTS (SLOTS)
    ) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .occ_vec (occ_vec),
        .install (fill_done),
        .vic_idx (vic_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_vpn  <= '0;
            held_asid <= '0;
            held_off  <= '0;
        end else if (capture) begin
            held_vpn  <= req_vpn;
            held_asid <= req_asid;
            held_off  <= req_off;
        end
    end

    assign served_hit = ready && req_valid && hit;

    always_comb begin
        rsp_valid = served_hit || fill_done;
        rsp_fault = 1'b0;
        rsp_paddr = '0;
        if (fill_done) begin
            rsp_fault = fill_fault;
            if (!fill_fault) begin
                rsp_paddr = {fill_pfn, held_off};
            end
        end else if (served_hit) begin
            rsp_fault = !hit_legal;
            if (hit_legal) begin
                rsp_paddr = {hit_pfn, req_off};
            end
        end
    end

    assign rsp_ready = ready;
    assign walk_req  = walking;
    assign walk_vpn  = held_vpn;
    assign walk_asid = held_asid;

endmodule

// File: rtl/xlat_cache_chk.sv
`timescale 1ns/1ps
module xlat_cache_chk #(
    parameter int VA_W   = 32,
    parameter int OFF_W  = 10,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 20,
    parameter int SLOTS  = 16,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PA_W  = PFN_W + OFF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [VA_W-1:0]   req_vaddr,
    input logic [ASID_W-1:0] req_asid,
    input logic              rsp_ready,
    input logic              rsp_valid,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic              rsp_fault,
    input logic              walk_req,
    input logic [VPN_W-1:0]  walk_vpn,
    input logic [ASID_W-1:0] walk_asid,
    input logic              fill_valid,
    input logic              fill_fault,
    input logic              flush_all,
    input logic              flush_sel,
    input logic [SLOTS-1:0]  hit_vec
);

    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault && !walk_req |-> rsp_paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0]);

    a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    a_r4_miss_starts_walk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready && req_valid && !rsp_valid |=>
            walk_req && walk_vpn == $past(req_vaddr[VA_W-1:OFF_W]) && walk_asid == $past(req_asid));

    a_r4_walk_held: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && !fill_valid |=> walk_req && $stable(walk_vpn) && $stable(walk_asid));

    a_r4_not_ready_walking: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> !rsp_ready);

    a_r5_fill_answers: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && fill_valid |-> rsp_valid && (rsp_fault == fill_fault));

    a_r5_walk_ends: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && fill_valid |=> !walk_req);

    a_r6_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid && rsp_paddr == '0);

    a_r8_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all || flush_sel |-> !rsp_ready);

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all && !(walk_req && fill_valid) |=> hit_vec == '0);

    a_r11_walk_silent: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && !fill_valid |-> !rsp_valid);

endmodule

bind xlat_cache xlat_cache_chk #(
    .VA_W   (VA_W),
    .OFF_W  (OFF_W),
    .ASID_W (ASID_W),
    .PFN_W  (PFN_W),
    .SLOTS  (SLOTS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .req_asid   (req_asid),
    .rsp_ready  (rsp_ready),
    .rsp_valid  (rsp_valid),
    .rsp_paddr  (rsp_paddr),
    .rsp_fault  (rsp_fault),
    .walk_req   (walk_req),
    .walk_vpn   (walk_vpn),
    .walk_asid  (walk_asid),
    .fill_valid (fill_valid),
    .fill_fault (fill_fault),
    .flush_all  (flush_all),
    .flush_sel  (flush_sel),
    .hit_vec    (hit_vec)
);

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
module test_xlat_cache;

    localparam int SLOTS = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic [7:0]  req_asid;
    logic        rsp_ready;
    logic        rsp_valid;
    logic [29:0] rsp_paddr;
    logic        rsp_fault;
    logic        walk_req;
    logic [21:0] walk_vpn;
    logic [7:0]  walk_asid;
    logic        fill_valid;
    logic [19:0] fill_pfn;
    logic        fill_fault;
    logic        flush_all;
    logic        flush_sel;
    logic [7:0]  flush_sel_asid;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    xlat_cache i_xlat_cache (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_vaddr      (req_vaddr),
        .req_asid       (req_asid),
        .rsp_ready      (rsp_ready),
        .rsp_valid      (rsp_valid),
        .rsp_paddr      (rsp_paddr),
        .rsp_fault      (rsp_fault),
        .walk_req       (walk_req),
        .walk_vpn       (walk_vpn),
        .walk_asid      (walk_asid),
        .fill_valid     (fill_valid),
        .fill_pfn       (fill_pfn),
        .fill_fault     (fill_fault),
        .flush_all      (flush_all),
        .flush_sel      (flush_sel),
        .flush_sel_asid (flush_sel_asid)
    );

    // walker stand-in: a fixed page table
    function automatic logic [19:0] pt_pfn(logic [21:0] v, logic [7:0] a);
        return v[19:0] ^ {a, 12'h5a3};
    endfunction

    function automatic logic pt_fault(logic [21:0] v);
        return v[21:20] == 2'b11;
    endfunction

    task automatic check(string what, logic [63:0] got, logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL [%s] %s got %h exp %h at %0t", cur_req, what, got, exp, $time);
        end
    endtask

    // reference model
    bit          m_occ  [SLOTS];
    logic [21:0] m_vpn  [SLOTS];
    logic [7:0]  m_asid [SLOTS];
    logic [19:0] m_pfn  [SLOTS];
    bit          m_ok   [SLOTS];
    int          m_rr;
    bit          m_walk;
    logic [21:0] m_wvpn;
    logic [7:0]  m_wasid;
    logic [9:0]  m_woff;

    bit          e_ready;
    bit          e_valid;
    bit          e_fault;
    logic [29:0] e_paddr;
    int          hit_at;
    int          vic;
    bit          full;

    always @(negedge clk) begin
        #5;
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) m_occ[s] = 1'b0;
            m_rr   = 0;
            m_walk = 1'b0;
        end else begin
            e_ready = !m_walk && !flush_all && !flush_sel;
            e_valid = 1'b0;
            e_fault = 1'b0;
            e_paddr = '0;
            hit_at  = -1;
            if (!m_walk) begin
                for (int s = 0; s < SLOTS; s++)
                    if (m_occ[s] && m_vpn[s] == req_vaddr[31:10] && m_asid[s] == req_asid) hit_at = s;
                if (e_ready && req_valid && hit_at >= 0) begin
                    e_valid = 1'b1;
                    e_fault = !m_ok[hit_at];
                    if (m_ok[hit_at]) e_paddr = {m_pfn[hit_at], req_vaddr[9:0]};
                end
            end else if (fill_valid) begin
                e_valid = 1'b1;
                e_fault = fill_fault;
                if (!fill_fault) e_paddr = {fill_pfn, m_woff};
            end
            check("rsp_ready", rsp_ready, e_ready);
            check("rsp_valid", rsp_valid, e_valid);
            check("rsp_fault", rsp_fault, e_fault);
            check("rsp_paddr", rsp_paddr, e_paddr);
            check("walk_req", walk_req, m_walk);
            if (m_walk) begin
                check("walk_vpn", walk_vpn, m_wvpn);
                check("walk_asid", walk_asid, m_wasid);
            end
            // state update for the coming edge
            vic = -1;
            for (int s = 0; s < SLOTS; s++) if (!m_occ[s] && vic < 0) vic = s;
            full = (vic < 0);
            if (full) vic = m_rr;
            for (int s = 0; s < SLOTS; s++)
                if (flush_all || (flush_sel && m_asid[s] == flush_sel_asid)) m_occ[s] = 1'b0;
            if (m_walk && fill_valid) begin
                m_occ[vic]  = 1'b1;
                m_vpn[vic]  = m_wvpn;
                m_asid[vic] = m_wasid;
                m_pfn[vic]  = fill_pfn;
                m_ok[vic]   = !fill_fault;
                if (full) m_rr = (m_rr + 1) % SLOTS;
                m_walk = 1'b0;
            end else if (!m_walk && e_ready && req_valid && hit_at < 0) begin
                m_walk  = 1'b1;
                m_wvpn  = req_vaddr[31:10];
                m_wasid = req_asid;
                m_woff  = req_vaddr[9:0];
            end
        end
    end

    task automatic access(logic [21:0] vpn, logic [7:0] asid, logic [9:0] off,
                          int lat, bit noise, bit flush_with_fill);
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = {vpn, off};
        req_asid  = asid;
        @(negedge clk);
        req_valid = 1'b0;
        if (walk_req) begin
            for (int i = 0; i < lat; i++) begin
                if (noise) begin
                    req_valid = 1'b1;
                    req_vaddr = $urandom;
                    req_asid  = 8'($urandom);
                end
                @(negedge clk);
                req_valid = 1'b0;
            end
            fill_valid = 1'b1;
            fill_pfn   = pt_pfn(vpn, asid);
            fill_fault = pt_fault(vpn);
            flush_all  = flush_with_fill;
            @(negedge clk);
            fill_valid = 1'b0;
            fill_fault = 1'b0;
            flush_all  = 1'b0;
        end
    endtask

    task automatic do_flush_all(bit with_req);
        @(negedge clk);
        flush_all = 1'b1;
        req_valid = with_req;
        @(negedge clk);
        flush_all = 1'b0;
        req_valid = 1'b0;
    endtask

    task automatic do_flush_sel(logic [7:0] a);
        @(negedge clk);
        flush_sel      = 1'b1;
        flush_sel_asid = a;
        @(negedge clk);
        flush_sel = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_vaddr = '0; req_asid = '0;
        fill_valid = 1'b0; fill_pfn = '0; fill_fault = 1'b0;
        flush_all = 1'b0; flush_sel = 1'b0; flush_sel_asid = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #7;
        cur_req = "R1";
        check("reset rsp_ready", rsp_ready, 1'b1);
        check("reset walk_req", walk_req, 1'b0);
        check("reset rsp_valid", rsp_valid, 1'b0);
        access(22'h00012, 8'd3, 10'h155, 2, 0, 0);     // R1: first access misses

        cur_req = "R2";
        access(22'h00012, 8'd3, 10'h2aa, 0, 0, 0);
        access(22'h00012, 8'd3, 10'h3ff, 0, 0, 0);

        cur_req = "R3";
        access(22'h00012, 8'd5, 10'h001, 1, 0, 0);
        access(22'h00012, 8'd3, 10'h002, 0, 0, 0);
        access(22'h00012, 8'd5, 10'h003, 0, 0, 0);

        cur_req = "R4";
        access(22'h1abcd, 8'd5, 10'h0f0, 4, 0, 0);

        cur_req = "R11";
        access(22'h00777, 8'd3, 10'h010, 5, 1, 0);
        access(22'h00777, 8'd3, 10'h011, 0, 0, 0);

        cur_req = "R6";
        access(22'h300005, 8'd3, 10'h020, 1, 0, 0);
        access(22'h300005, 8'd3, 10'h021, 0, 0, 0);

        cur_req = "R9";
        do_flush_sel(8'd5);
        access(22'h00012, 8'd3, 10'h030, 0, 0, 0);
        access(22'h00012, 8'd5, 10'h031, 1, 0, 0);

        cur_req = "R8";
        do_flush_all(1'b1);
        access(22'h00012, 8'd3, 10'h040, 1, 0, 0);
        access(22'h00777, 8'd3, 10'h041, 1, 0, 0);

        cur_req = "R7";
        do_flush_all(1'b0);
        for (int k = 0; k < 18; k++) access(22'(k + 32), 8'd1, 10'h050, 0, 0, 0);
        for (int k = 0; k < 18; k++) access(22'(k + 32), 8'd1, 10'h051, 0, 0, 0);
        do_flush_all(1'b0);
        for (int k = 0; k < 16; k++) access(22'(k + 64), 8'((k % 2) + 1), 10'h060, 0, 0, 0);
        do_flush_sel(8'd2);
        for (int k = 0; k < 9; k++) access(22'(k + 96), 8'd4, 10'h061, 0, 0, 0);
        for (int k = 0; k < 16; k++) access(22'(k + 64), 8'd1, 10'h062, 0, 0, 0);

        cur_req = "R10";
        access(22'h02468, 8'd6, 10'h070, 1, 0, 1);
        access(22'h02468, 8'd6, 10'h071, 0, 0, 0);

        cur_req = "R5";
        for (int n = 0; n < 400; n++) begin
            int k;
            k = int'($urandom_range(0, 23));
            if ($urandom_range(0, 19) == 0) do_flush_sel(8'($urandom_range(1, 3)));
            else if ($urandom_range(0, 39) == 0) do_flush_all(1'($urandom_range(0, 1)));
            access((k % 4 == 3) ? (22'h300000 | 22'(k)) : 22'(k),
                   8'($urandom_range(1, 3)), 10'($urandom),
                   int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'b0);
        end

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL [%s] watchdog expired got running exp finished", cur_req);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule